// File: doc/BRIEF.md
# Chained Even/Odd Event Counter Pair

This block holds two event counters of equal width: a low (even) half and a high (odd) half. The low half counts an event strobe. The high half normally counts its own strobe. When its event-type field holds the chain code, it instead counts the wraps of the low half. The pair then behaves as one counter of twice the width.

Each half has its own enable. A global enable gates both halves. Software can preset either half through a write strobe and data bus. A wrap of either half sets a sticky overflow flag for that half, and a per-bit clear input drops the flag again.

The carry from the low half is formed in the same cycle as the low half's wrap. Both halves therefore change on the same clock edge. Chaining can be turned on or off between events without disturbing either value.

The block samples an asynchronous active-low reset and releases it internally through a two-stage synchronizer.

Top module: `chain_pair_ctr`

## Requirements
- R1: While reset is active, and immediately after it is released, both counters read 0 and both overflow flags read 0.
- R2: The low counter increments by one on each clock where `glb_en_i`, `lo_en_i` and `lo_evt_i` are all 1. From all-ones it wraps to 0 and sets overflow bit 0.
- R3: When `hi_type_i` equals 16'h001E (chain mode), the high counter increments by one on the same edge on which the low counter wraps. In chain mode, `hi_evt_i` has no effect.
- R4: In chain mode, a carry into a high counter that holds all-ones wraps it to 0 and sets overflow bit 1, in addition to bit 0.
- R5: In chain mode the high counter does not change while `lo_en_i` is 0. While `hi_en_i` is 0, a low wrap still sets overflow bit 0 and leaves the high counter unchanged.
- R6: While `glb_en_i` is 0, neither counter changes on event strobes.
- R7: A low wrap that happens while the high half is not in chain mode is never carried later. Switching the mode while counting takes effect from the next event without altering either stored value.
- R8: With any other `hi_type_i` value, the high counter counts `hi_evt_i` (gated by `glb_en_i` and `hi_en_i`), independently of the low half. A low wrap then sets only overflow bit 0.
- R9: A preset write replaces that counter's value on the next edge and takes priority over an increment or carry in the same cycle. A low preset in that cycle produces no wrap.
- R10: Overflow flags stay set until their bit in `ovf_clr_i` is 1 (bit 0 low half, bit 1 high half). A set in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| glb_en_i | input | 1 | Global count enable |
| lo_en_i | input | 1 | Low (even) counter enable |
| hi_en_i | input | 1 | High (odd) counter enable |
| lo_evt_i | input | 1 | Event strobe for the low counter |
| hi_evt_i | input | 1 | Event strobe for the high counter when not chained |
| hi_type_i | input | EVT_W (16) | High counter event type; 16'h001E selects chain mode |
| lo_wr_i | input | 1 | Preset strobe, low counter |
| lo_wr_data_i | input | CNT_W (32) | Preset value, low counter |
| hi_wr_i | input | 1 | Preset strobe, high counter |
| hi_wr_data_i | input | CNT_W (32) | Preset value, high counter |
| ovf_clr_i | input | 2 | Per-half overflow flag clear |
| lo_cnt_o | output | CNT_W (32) | Low counter value |
| hi_cnt_o | output | CNT_W (32) | High counter value |
| ovf_o | output | 2 | Sticky overflow flags, bit 0 low, bit 1 high |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- A carry registered a cycle late would show the low half at 0 with the high half still one behind on the same sample.
- A carry taken from the raw strobe instead of the wrap would advance the high half while `lo_en_i` is low.
- A design that remembered a wrap would credit it to the high half once chain mode is switched on after the wrap.
- The high half must roll from all-ones to 0 and set both flags, and chain mode must ignore the high strobe.
- The preset path must beat the carry path when both occur in one cycle.
- A flag that is set and cleared in the same cycle must end up set.

// File: rtl/chain_pair_pkg.sv
package chain_pair_pkg;
  localparam int unsigned CPR_CNT_W     = 32;
  localparam int unsigned CPR_EVT_W     = 16;
  localparam logic [CPR_EVT_W-1:0] CPR_CHAIN_EVT = 16'h001E;
  localparam int unsigned CPR_HALVES    = 2;
  localparam int unsigned CPR_SYNC_STG  = 2;
endpackage

// File: rtl/cpr_rst_sync.sv
module cpr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/cpr_half.sv
module cpr_half #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  // Preset beats increment; the enable is written out for clock gating.
  always_comb begin
    cnt_ce = wr_i | inc_i;
    cnt_d  = cnt_q;
    if (wr_i)       cnt_d = wr_data_i;
    else if (inc_i) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~wr_i & (&cnt_q);
endmodule

// File: rtl/cpr_link.sv
module cpr_link #(
  parameter int unsigned           EVT_W     = 16,
  parameter logic [EVT_W-1:0]      CHAIN_EVT = 16'h001E
) (
  input  logic             glb_en_i,
  input  logic             lo_en_i,
  input  logic             hi_en_i,
  input  logic             lo_evt_i,
  input  logic             hi_evt_i,
  input  logic [EVT_W-1:0] hi_type_i,
  input  logic             lo_wrap_i,
  output logic             lo_inc_o,
  output logic             hi_inc_o
);
  logic chained;
  logic hi_src;

  always_comb begin
    chained  = (hi_type_i == CHAIN_EVT);
    lo_inc_o = glb_en_i & lo_en_i & lo_evt_i;
    // Carry comes from this cycle's wrap only, never from a stored one.
    hi_src   = chained ? lo_wrap_i : hi_evt_i;
    hi_inc_o = glb_en_i & hi_en_i & hi_src;
  end
endmodule

// File: rtl/cpr_flags.sv
module cpr_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flg_q;
    logic flg_d;
    logic flg_ce;

    always_comb begin
      flg_ce = set_i[g] | clr_i[g];
      flg_d  = set_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flg_q <= 1'b0;
      else if (flg_ce) flg_q <= flg_d;
    end

    assign flags_o[g] = flg_q;
  end
endmodule

// File: rtl/chain_pair_ctr.sv
module chain_pair_ctr
  import chain_pair_pkg::*;
#(
  parameter int unsigned          CNT_W     = CPR_CNT_W,
  parameter int unsigned          EVT_W     = CPR_EVT_W,
  parameter logic [EVT_W-1:0]     CHAIN_EVT = CPR_CHAIN_EVT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic             lo_en_i,
  input  logic             hi_en_i,
  input  logic             lo_evt_i,
  input  logic             hi_evt_i,
  input  logic [EVT_W-1:0] hi_type_i,
  input  logic             lo_wr_i,
  input  logic [CNT_W-1:0] lo_wr_data_i,
  input  logic             hi_wr_i,
  input  logic [CNT_W-1:0] hi_wr_data_i,
  input  logic [1:0]       ovf_clr_i,
  output logic [CNT_W-1:0] lo_cnt_o,
  output logic [CNT_W-1:0] hi_cnt_o,
  output logic [1:0]       ovf_o
);
  localparam int unsigned NH = CPR_HALVES;

  logic             rst_sync_n;
  logic [NH-1:0]    inc;
  logic [NH-1:0]    wr;
  logic [NH-1:0]    wrap;
  logic [CNT_W-1:0] wdata [NH];
  logic [CNT_W-1:0] cnt   [NH];

  cpr_rst_sync #(.STAGES(CPR_SYNC_STG)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  cpr_link #(.EVT_W(EVT_W), .CHAIN_EVT(CHAIN_EVT)) u_link (
    .glb_en_i  (glb_en_i),
    .lo_en_i   (lo_en_i),
    .hi_en_i   (hi_en_i),
    .lo_evt_i  (lo_evt_i),
    .hi_evt_i  (hi_evt_i),
    .hi_type_i (hi_type_i),
    .lo_wrap_i (wrap[0]),
    .lo_inc_o  (inc[0]),
    .hi_inc_o  (inc[1])
  );

  assign wr[0]    = lo_wr_i;
  assign wr[1]    = hi_wr_i;
  assign wdata[0] = lo_wr_data_i;
  assign wdata[1] = hi_wr_data_i;

  for (genvar h = 0; h < NH; h++) begin : g_half
    cpr_half #(.W(CNT_W)) u_half (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .inc_i     (inc[h]),
      .wr_i      (wr[h]),
      .wr_data_i (wdata[h]),
      .cnt_o     (cnt[h]),
      .wrap_o    (wrap[h])
    );
  end

  cpr_flags #(.N(NH)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .set_i   (wrap),
    .clr_i   (ovf_clr_i),
    .flags_o (ovf_o)
  );

  assign lo_cnt_o = cnt[0];
  assign hi_cnt_o = cnt[1];
endmodule

// File: rtl/cpr_chk.sv
module cpr_chk #(
  parameter int unsigned      CNT_W     = 32,
  parameter int unsigned      EVT_W     = 16,
  parameter logic [EVT_W-1:0] CHAIN_EVT = 16'h001E
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glb_en_i,
  input logic             lo_en_i,
  input logic             hi_en_i,
  input logic             lo_evt_i,
  input logic [EVT_W-1:0] hi_type_i,
  input logic             lo_wr_i,
  input logic [CNT_W-1:0] lo_wr_data_i,
  input logic             hi_wr_i,
  input logic [1:0]       ovf_clr_i,
  input logic [CNT_W-1:0] lo_cnt_o,
  input logic [CNT_W-1:0] hi_cnt_o,
  input logic [1:0]       ovf_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assert_lo_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en_i && lo_en_i && lo_evt_i && !lo_wr_i && lo_cnt_o != '1)
    |=> (lo_cnt_o == $past(lo_cnt_o) + ONE));

  assert_carry_same_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en_i && lo_en_i && lo_evt_i && !lo_wr_i && lo_cnt_o == '1 &&
     hi_en_i && hi_type_i == CHAIN_EVT && !hi_wr_i && hi_cnt_o != '1)
    |=> (lo_cnt_o == '0 && hi_cnt_o == $past(hi_cnt_o) + ONE));

  assert_hi_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en_i && lo_en_i && lo_evt_i && !lo_wr_i && lo_cnt_o == '1 &&
     hi_en_i && hi_type_i == CHAIN_EVT && !hi_wr_i && hi_cnt_o == '1)
    |=> (hi_cnt_o == '0 && ovf_o == 2'b11));

  assert_no_carry_lo_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_type_i == CHAIN_EVT && !lo_en_i && !hi_wr_i) |=> $stable(hi_cnt_o));

  assert_global_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en_i && !lo_wr_i && !hi_wr_i) |=> ($stable(lo_cnt_o) && $stable(hi_cnt_o)));

  assert_preset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i |=> (lo_cnt_o == $past(lo_wr_data_i)));

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o[0] && !ovf_clr_i[0]) |=> ovf_o[0]);
endmodule

bind chain_pair_ctr cpr_chk #(.CNT_W(CNT_W), .EVT_W(EVT_W), .CHAIN_EVT(CHAIN_EVT)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_sync_n),
  .glb_en_i     (glb_en_i),
  .lo_en_i      (lo_en_i),
  .hi_en_i      (hi_en_i),
  .lo_evt_i     (lo_evt_i),
  .hi_type_i    (hi_type_i),
  .lo_wr_i      (lo_wr_i),
  .lo_wr_data_i (lo_wr_data_i),
  .hi_wr_i      (hi_wr_i),
  .ovf_clr_i    (ovf_clr_i),
  .lo_cnt_o     (lo_cnt_o),
  .hi_cnt_o     (hi_cnt_o),
  .ovf_o        (ovf_o)
);

// File: tb/chain_pair_ctr_tb_top.sv
module chain_pair_ctr_tb_top;
  localparam logic [15:0] CHAIN = 16'h001E;
  localparam logic [15:0] PLAIN = 16'h0011;
  localparam int VW = 142;
  localparam int NV = 9;
  // {lo0, hi0, chain, lo_en, hi_en, hi_evt, n, exp_lo, exp_hi, exp_ovf}
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'hFFFFFFF0, 32'h00000000, 1'b1, 1'b1, 1'b1, 1'b1, 8'd32,  32'h00000010, 32'h00000001, 2'b01},
    {32'hFFFFFFF0, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 8'd32,  32'h00000010, 32'h00000000, 2'b11},
    {32'hFFFFFFF0, 32'h00000001, 1'b1, 1'b1, 1'b1, 1'b0, 8'd32,  32'h00000010, 32'h00000002, 2'b01},
    {32'hFFFFFFF0, 32'h00000000, 1'b1, 1'b0, 1'b1, 1'b0, 8'd32,  32'hFFFFFFF0, 32'h00000000, 2'b00},
    {32'hFFFFFFF0, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0, 8'd32,  32'h00000010, 32'h00000000, 2'b01},
    {32'hFFFFFFF0, 32'h00000005, 1'b0, 1'b1, 1'b1, 1'b1, 8'd32,  32'h00000010, 32'h00000025, 2'b01},
    {32'h00000000, 32'hFFFFFFF0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd20,  32'h00000014, 32'h00000004, 2'b10},
    {32'h00000000, 32'h00000000, 1'b1, 1'b1, 1'b1, 1'b0, 8'd100, 32'h00000064, 32'h00000000, 2'b00},
    {32'hFFFFFFDC, 32'h00000000, 1'b1, 1'b1, 1'b1, 1'b0, 8'd36,  32'h00000000, 32'h00000001, 2'b01}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        glb_en, lo_en, hi_en, lo_evt, hi_evt, lo_wr, hi_wr;
  logic [15:0] hi_type;
  logic [31:0] lo_wd, hi_wd, lo_cnt, hi_cnt;
  logic [1:0]  ovf_clr, ovf;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  chain_pair_ctr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .lo_en_i(lo_en), .hi_en_i(hi_en),
    .lo_evt_i(lo_evt), .hi_evt_i(hi_evt), .hi_type_i(hi_type),
    .lo_wr_i(lo_wr), .lo_wr_data_i(lo_wd), .hi_wr_i(hi_wr), .hi_wr_data_i(hi_wd),
    .ovf_clr_i(ovf_clr), .lo_cnt_o(lo_cnt), .hi_cnt_o(hi_cnt), .ovf_o(ovf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic idle();
    glb_en = 0; lo_en = 0; hi_en = 0; lo_evt = 0; hi_evt = 0;
    lo_wr = 0; hi_wr = 0; ovf_clr = 2'b00;
  endtask

  // Preset both halves and clear flags with counting stopped.
  task automatic preset(input logic [31:0] lo, input logic [31:0] hi, input logic [15:0] ty);
    idle();
    hi_type = ty; lo_wr = 1; hi_wr = 1; lo_wd = lo; hi_wd = hi; ovf_clr = 2'b11;
    step(1);
    idle();
  endtask

  initial begin
    rst_n = 0; hi_type = PLAIN; lo_wd = '0; hi_wd = '0;
    idle();
    step(3);
    chk("R1 lo in reset", lo_cnt, 32'h0);
    chk("R1 hi in reset", hi_cnt, 32'h0);
    rst_n = 1;
    step(3);
    chk("R1 lo after release", lo_cnt, 32'h0);
    chk("R1 ovf after release", {30'h0, ovf}, 32'h0);

    // Vector table: R2 R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      preset(e[141:110], e[109:78], e[77] ? CHAIN : PLAIN);
      glb_en = 1; lo_en = e[76]; hi_en = e[75]; hi_evt = e[74]; lo_evt = 1;
      step(int'(e[73:66]));
      chk($sformatf("R2/R3/R4/R5/R8 vec%0d lo", v), lo_cnt, e[65:34]);
      chk($sformatf("R3/R4/R5/R8 vec%0d hi", v), hi_cnt, e[33:2]);
      chk($sformatf("R2/R4/R8 vec%0d ovf", v), {30'h0, ovf}, {30'h0, e[1:0]});
      idle();
    end

    // R6: global enable low blocks both halves
    preset(32'h5, 32'h7, PLAIN);
    lo_en = 1; hi_en = 1; lo_evt = 1; hi_evt = 1;
    step(10);
    chk("R6 lo held", lo_cnt, 32'h5);
    chk("R6 hi held", hi_cnt, 32'h7);

    // R7: wrap before chaining is not carried afterwards
    preset(32'hFFFFFFFF, 32'h0, PLAIN);
    glb_en = 1; lo_en = 1; hi_en = 1; lo_evt = 1;
    step(1);
    chk("R7 lo wrapped", lo_cnt, 32'h0);
    chk("R7 ovf0 set", {30'h0, ovf}, 32'h1);
    lo_evt = 0; hi_type = CHAIN;
    step(3);
    lo_evt = 1;
    step(3);
    chk("R7 no late carry hi", hi_cnt, 32'h0);
    chk("R7 lo continues", lo_cnt, 32'h3);

    // R3: carry and wrap on the same edge
    preset(32'hFFFFFFFE, 32'h0, CHAIN);
    glb_en = 1; lo_en = 1; hi_en = 1; lo_evt = 1;
    step(1);
    chk("R3 before wrap hi", hi_cnt, 32'h0);
    step(1);
    chk("R3 same edge lo", lo_cnt, 32'h0);
    chk("R3 same edge hi", hi_cnt, 32'h1);
    // R7: switch to ordinary mode while counting
    hi_type = PLAIN; hi_evt = 1;
    step(4);
    chk("R7 switch lo", lo_cnt, 32'h4);
    chk("R7 switch hi", hi_cnt, 32'h5);
    idle();

    // R9: preset beats increment and carry
    preset(32'hFFFFFFFF, 32'h0, CHAIN);
    glb_en = 1; lo_en = 1; hi_en = 1; lo_evt = 1; hi_wr = 1; hi_wd = 32'h50;
    step(1);
    chk("R9 hi write beats carry", hi_cnt, 32'h50);
    chk("R9 lo wrapped", lo_cnt, 32'h0);
    idle();
    preset(32'hFFFFFFFF, 32'h0, CHAIN);
    glb_en = 1; lo_en = 1; hi_en = 1; lo_evt = 1; lo_wr = 1; lo_wd = 32'h7;
    step(1);
    chk("R9 lo write beats inc", lo_cnt, 32'h7);
    chk("R9 no wrap flag", {30'h0, ovf}, 32'h0);
    chk("R9 no carry", hi_cnt, 32'h0);
    idle();

    // R10: sticky flags and set-over-clear
    preset(32'hFFFFFFFF, 32'h0, PLAIN);
    glb_en = 1; lo_en = 1; lo_evt = 1;
    step(1);
    idle();
    step(5);
    chk("R10 sticky", {30'h0, ovf}, 32'h1);
    ovf_clr = 2'b01;
    step(1);
    ovf_clr = 2'b00;
    chk("R10 cleared", {30'h0, ovf}, 32'h0);
    lo_wr = 1; lo_wd = 32'hFFFFFFFF;
    step(1);
    lo_wr = 0; glb_en = 1; lo_en = 1; lo_evt = 1; ovf_clr = 2'b01;
    step(1);
    idle();
    chk("R10 set wins over clear", {30'h0, ovf}, 32'h1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule